// File: doc/BRIEF.md
# Serial Message Framer with Pacing

This block turns a stream of 7-bit ASCII characters, handed over one at a time with a valid/ready handshake and an end-of-message flag, into asynchronous serial frames on a single transmit line. Each message can be preceded by a header string of up to ten characters. It is followed by a terminator, which is either one of four fixed choices or a user string of up to ten characters. The header and the user terminator are loaded through a small register port.

Strap inputs fix the bit rate, the parity mode and the number of stop bits. All bit timing is derived from the block clock through the `CLK_HZ` parameter, so the rates scale when the clock differs from 12 MHz. A companion receiver passes in received characters. When pacing is enabled, an XOFF character (13h) holds the output and an XON character (11h) releases it. A hold only takes effect between characters.

Register port map (`cfg_addr`, default `MAX_STR` = 10): addresses 0..9 hold the header characters and address 10 holds the header length. Addresses 16..25 hold the user terminator characters and address 26 holds its length. Address 31 bit 0 enables pacing. A length write above 10 is stored as 10. All registers reset to zero, so by default there is no header, the strap terminator is used and pacing is off.

Top module: `serial_msg_framer`

## Requirements
- R1: While reset is asserted and after its release with no traffic, `txd` is 1 and `msg_ready` is 0.
- R2: Each character is framed as one start bit at 0, then 7 data bits LSB first, then one parity bit, then the stop bits at 1; the line idles at 1.
- R3: `strap_baud` selects the bit period as `CLK_HZ`/rate clocks: 11 = 300, 10 = 1200, 01 = 2400, 00 = 9600 baud. Within a message, consecutive characters start (bits per frame × period + 1) clocks apart.
- R4: `strap_parity` selects the parity bit: 11 = always 0, 10 = always 1, 01 = odd over the 7 data bits, 00 = even over the 7 data bits.
- R5: `strap_stop2` = 1 gives two stop bits (11-bit frame) and 0 gives one stop bit (10-bit frame).
- R6: With no user terminator loaded, `strap_term` appends 11 = CR (0Dh), 10 = CR then LF (0Ah), 01 = HT (09h), 00 = nothing after the message character flagged `msg_last`.
- R7: A nonzero user terminator length replaces the strap terminator with that many loaded characters, sent in index order. Writing length 0 restores the strap choice.
- R8: A nonzero header length sends that many loaded header characters, in index order, before the first character of every message. At reset no header is sent.
- R9: With pacing enabled, a received XOFF stops new characters from starting and a received XON lets them start again. With pacing disabled, received XOFF has no effect.
- R10: An XOFF received while a character is on the line lets that character finish with all its stop bits; only the following characters are held.
- R11: Disabling pacing while output is held lets transmission continue at once, with no XON.
- R12: `msg_ready` is 1 only in a cycle in which the offered message character is taken for transmission. Every taken character is sent exactly once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, rate given by `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| msg_valid | input | 1 | Message character offered |
| msg_data | input | 7 | Offered ASCII character |
| msg_last | input | 1 | Offered character ends the message |
| msg_ready | output | 1 | Offered character taken this cycle |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register address (map above) |
| cfg_data | input | 7 | Register write data |
| strap_baud | input | 2 | Bit rate select |
| strap_parity | input | 2 | Parity mode select |
| strap_stop2 | input | 1 | 1 = two stop bits |
| strap_term | input | 2 | Fixed terminator select |
| rx_valid | input | 1 | Companion receiver has a character |
| rx_char | input | 7 | Received character |
| txd | output | 1 | Serial transmit line |

## Verification
A bad bit counter or divisor latch in the transmitter shows up within a single character time as a missing stop bit, a shifted data bit or a start-to-start spacing off by a bit period. A wrong header or terminator index shows in the first framed message as a wrong or missing character, and a wrong length shows as an extra or missing character. A hold flag that does not clear leaves the line idle and `msg_ready` low after XON or after pacing is disabled. A hold flag that is set too late lets a second character start after an XOFF, so the mid-character XOFF case shows the fault on the very next character boundary.

// File: rtl/sframe_pkg.sv
package sframe_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_HDR,
    SEQ_MSG,
    SEQ_TRM
  } seq_state_e;

  localparam logic [6:0] CH_CR   = 7'h0D;
  localparam logic [6:0] CH_LF   = 7'h0A;
  localparam logic [6:0] CH_HT   = 7'h09;
  localparam logic [6:0] CH_XON  = 7'h11;
  localparam logic [6:0] CH_XOFF = 7'h13;

  // parity bit for a 7-bit character under the strap mode
  function automatic logic calc_parity(input logic [1:0] sel, input logic [6:0] d);
    logic p;
    case (sel)
      2'b11:   p = 1'b0;
      2'b10:   p = 1'b1;
      2'b01:   p = ~(^d);
      default: p = ^d;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sframe_cfg_store.sv
module sframe_cfg_store #(
  parameter int MAX_STR = 10,
  parameter int AW      = 5,
  localparam int LW     = $clog2(MAX_STR + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [6:0]    wdata,
  input  logic [LW-1:0] hdr_idx,
  output logic [6:0]    hdr_char,
  output logic [LW-1:0] hdr_len,
  input  logic [LW-1:0] trm_idx,
  output logic [6:0]    trm_char,
  output logic [LW-1:0] trm_len,
  output logic          pace_en
);

  localparam int TRM_BASE  = 2 ** (AW - 1);
  localparam int HLEN_ADDR = MAX_STR;
  localparam int TLEN_ADDR = TRM_BASE + MAX_STR;
  localparam int PACE_ADDR = 2 ** AW - 1;

  logic [6:0]    hdr_q [MAX_STR];
  logic [6:0]    trm_q [MAX_STR];
  logic [LW-1:0] hlen_q, tlen_q, len_wr;
  logic          pace_q;

  always_comb begin
    if (int'(wdata) > MAX_STR) len_wr = LW'(MAX_STR);
    else                       len_wr = wdata[LW-1:0];
  end

  for (genvar g = 0; g < MAX_STR; g++) begin : g_slot
    logic hdr_en, trm_en;
    assign hdr_en = we && (addr == AW'(g));
    assign trm_en = we && (addr == AW'(TRM_BASE + g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      hdr_q[g] <= '0;
      else if (hdr_en) hdr_q[g] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      trm_q[g] <= '0;
      else if (trm_en) trm_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hlen_q <= '0;
      tlen_q <= '0;
      pace_q <= 1'b0;
    end else if (we) begin
      if (addr == AW'(HLEN_ADDR)) hlen_q <= len_wr;
      if (addr == AW'(TLEN_ADDR)) tlen_q <= len_wr;
      if (addr == AW'(PACE_ADDR)) pace_q <= wdata[0];
    end
  end

  assign hdr_char = (int'(hdr_idx) < MAX_STR) ? hdr_q[hdr_idx] : 7'h00;
  assign trm_char = (int'(trm_idx) < MAX_STR) ? trm_q[trm_idx] : 7'h00;
  assign hdr_len  = hlen_q;
  assign trm_len  = tlen_q;
  assign pace_en  = pace_q;

  // R8
  hdr_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hdr_len) <= MAX_STR);

  // R7
  trm_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(trm_len) <= MAX_STR);

endmodule

// File: rtl/sframe_pace.sv
module sframe_pace
  import sframe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pace_en,
  input  logic       rx_valid,
  input  logic [6:0] rx_char,
  output logic       hold
);

  logic hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (!pace_en)                            hold_d = 1'b0;
    else if (rx_valid && rx_char == CH_XOFF) hold_d = 1'b1;
    else if (rx_valid && rx_char == CH_XON)  hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign hold = hold_q && pace_en;

  // R9
  xoff_sets_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pace_en && rx_valid && rx_char == CH_XOFF) |=> (hold || !pace_en));

  // R9
  xon_clears_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_char == CH_XON) |=> !hold);

endmodule

// File: rtl/sframe_tx_core.sv
module sframe_tx_core
  import sframe_pkg::*;
#(
  parameter int CLK_HZ = 12_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [6:0] char_in,
  input  logic [1:0] baud_sel,
  input  logic [1:0] par_sel,
  input  logic       stop2,
  output logic       busy,
  output logic       txd
);

  localparam int D300  = CLK_HZ / 300;
  localparam int D1200 = CLK_HZ / 1200;
  localparam int D2400 = CLK_HZ / 2400;
  localparam int D9600 = CLK_HZ / 9600;
  localparam int DIV_W = $clog2(D300 + 1);
  localparam int FR_W  = 11;

  logic [DIV_W-1:0] div_m1, divl_q, divl_d, cnt_q, cnt_d;
  logic [FR_W-1:0]  frame_q, frame_d;
  logic [3:0]       bit_q, bit_d, last_q, last_d;
  logic             busy_q, busy_d, txd_q, txd_d;

  always_comb begin
    case (baud_sel)
      2'b11:   div_m1 = DIV_W'(D300 - 1);
      2'b10:   div_m1 = DIV_W'(D1200 - 1);
      2'b01:   div_m1 = DIV_W'(D2400 - 1);
      default: div_m1 = DIV_W'(D9600 - 1);
    endcase
  end

  always_comb begin
    frame_d = frame_q;
    divl_d  = divl_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    last_d  = last_q;
    busy_d  = busy_q;
    txd_d   = txd_q;
    if (start && !busy_q) begin
      frame_d = {2'b11, calc_parity(par_sel, char_in), char_in, 1'b0};
      divl_d  = div_m1;
      cnt_d   = div_m1;
      bit_d   = 4'd0;
      last_d  = stop2 ? 4'd10 : 4'd9;
      busy_d  = 1'b1;
      txd_d   = 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        if (bit_q == last_q) begin
          busy_d = 1'b0;
          txd_d  = 1'b1;
        end else begin
          bit_d   = bit_q + 4'd1;
          frame_d = {1'b1, frame_q[FR_W-1:1]};
          txd_d   = frame_q[1];
          cnt_d   = divl_q;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      divl_q  <= '0;
      cnt_q   <= '0;
      bit_q   <= '0;
      last_q  <= 4'd9;
      busy_q  <= 1'b0;
      txd_q   <= 1'b1;
    end else begin
      frame_q <= frame_d;
      divl_q  <= divl_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      last_q  <= last_d;
      busy_q  <= busy_d;
      txd_q   <= txd_d;
    end
  end

  assign busy = busy_q;
  assign txd  = txd_q;

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd_q);

  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> $stable(txd_q));

  // R5
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (bit_q <= last_q));

  // R12
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

endmodule

// File: rtl/serial_msg_framer.sv
module serial_msg_framer
  import sframe_pkg::*;
#(
  parameter int CLK_HZ  = 12_000_000,
  parameter int MAX_STR = 10,
  parameter int CFG_AW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  logic [6:0]        msg_data,
  input  logic              msg_last,
  output logic              msg_ready,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [6:0]        cfg_data,
  input  logic [1:0]        strap_baud,
  input  logic [1:0]        strap_parity,
  input  logic              strap_stop2,
  input  logic [1:0]        strap_term,
  input  logic              rx_valid,
  input  logic [6:0]        rx_char,
  output logic              txd
);

  localparam int LW = $clog2(MAX_STR + 1);

  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  seq_state_e    state_q, state_d;
  logic [LW-1:0] idx_q, idx_d;
  logic [LW-1:0] hdr_len, usr_trm_len, term_len;
  logic [6:0]    hdr_char, usr_trm_char, term_char, cur_char;
  logic          pace_en, hold, tx_busy, tx_start, can_go;

  sframe_cfg_store #(.MAX_STR(MAX_STR), .AW(CFG_AW)) u_store (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_data),
    .hdr_idx  (idx_q),
    .hdr_char (hdr_char),
    .hdr_len  (hdr_len),
    .trm_idx  (idx_q),
    .trm_char (usr_trm_char),
    .trm_len  (usr_trm_len),
    .pace_en  (pace_en)
  );

  sframe_pace u_pace (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .pace_en  (pace_en),
    .rx_valid (rx_valid),
    .rx_char  (rx_char),
    .hold     (hold)
  );

  sframe_tx_core #(.CLK_HZ(CLK_HZ)) u_tx (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .start    (tx_start),
    .char_in  (cur_char),
    .baud_sel (strap_baud),
    .par_sel  (strap_parity),
    .stop2    (strap_stop2),
    .busy     (tx_busy),
    .txd      (txd)
  );

  // terminator source: user string wins over the strap
  always_comb begin
    if (usr_trm_len != '0) begin
      term_len  = usr_trm_len;
      term_char = usr_trm_char;
    end else begin
      case (strap_term)
        2'b11: begin
          term_len  = LW'(1);
          term_char = CH_CR;
        end
        2'b10: begin
          term_len  = LW'(2);
          term_char = (idx_q == '0) ? CH_CR : CH_LF;
        end
        2'b01: begin
          term_len  = LW'(1);
          term_char = CH_HT;
        end
        default: begin
          term_len  = '0;
          term_char = CH_CR;
        end
      endcase
    end
  end

  always_comb begin
    case (state_q)
      SEQ_HDR: cur_char = hdr_char;
      SEQ_TRM: cur_char = term_char;
      default: cur_char = msg_data;
    endcase
  end

  assign can_go    = !tx_busy && !hold;
  assign msg_ready = can_go && (state_q == SEQ_MSG);
  assign tx_start  = can_go && ((state_q == SEQ_HDR) || (state_q == SEQ_TRM) ||
                                ((state_q == SEQ_MSG) && msg_valid));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      SEQ_IDLE: begin
        if (msg_valid) begin
          state_d = (hdr_len != '0) ? SEQ_HDR : SEQ_MSG;
          idx_d   = '0;
        end
      end
      SEQ_HDR: begin
        if (tx_start) begin
          if (idx_q == hdr_len - 1'b1) begin
            state_d = SEQ_MSG;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      SEQ_MSG: begin
        if (tx_start && msg_last) begin
          state_d = (term_len != '0) ? SEQ_TRM : SEQ_IDLE;
          idx_d   = '0;
        end
      end
      default: begin
        if (tx_start) begin
          if (idx_q == term_len - 1'b1) begin
            state_d = SEQ_IDLE;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  // R9
  no_start_on_hold_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    hold |-> !tx_start);

  // R12
  ready_in_msg_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    msg_ready |-> (state_q == SEQ_MSG));

  // R8
  hdr_index_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state_q == SEQ_HDR) |-> (idx_q < hdr_len));

  // R6
  trm_index_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state_q == SEQ_TRM) |-> (idx_q < term_len));

endmodule

// File: tb/serial_msg_framer_test.sv
`timescale 1ns/1ps
module serial_msg_framer_test;

  localparam int CLK_HZ = 38400;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       msg_valid, msg_last, msg_ready;
  logic [6:0] msg_data;
  logic       cfg_we;
  logic [4:0] cfg_addr;
  logic [6:0] cfg_data;
  logic [1:0] strap_baud, strap_parity, strap_term;
  logic       strap_stop2;
  logic       rx_valid;
  logic [6:0] rx_char;
  logic       txd;

  always #4 clk = ~clk;

  serial_msg_framer #(.CLK_HZ(CLK_HZ), .MAX_STR(10), .CFG_AW(5)) uut (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_data(msg_data), .msg_last(msg_last), .msg_ready(msg_ready),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .strap_baud(strap_baud), .strap_parity(strap_parity),
    .strap_stop2(strap_stop2), .strap_term(strap_term),
    .rx_valid(rx_valid), .rx_char(rx_char), .txd(txd)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // captured frames
  int         mon_n = 0;
  logic [6:0] mon_d [64];
  logic       mon_p [64];
  logic       mon_s [64];
  int         mon_t [64];
  logic [10:0] mon_bits;
  int          mon_dv, mon_nb, mon_t0;

  // expected sequence
  int         exp_n;
  logic [6:0] exp_d [64];
  logic [6:0] msg_buf [64];

  function automatic int div_of(input logic [1:0] b);
    case (b)
      2'b11:   return 128;
      2'b10:   return 32;
      2'b01:   return 16;
      default: return 4;
    endcase
  endfunction

  function automatic logic exp_par(input logic [1:0] s, input logic [6:0] d);
    case (s)
      2'b11:   return 1'b0;
      2'b10:   return 1'b1;
      2'b01:   return ~(^d);
      default: return ^d;
    endcase
  endfunction

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && txd === 1'b0) begin
        mon_dv = div_of(strap_baud);
        mon_nb = strap_stop2 ? 11 : 10;
        mon_t0 = cyc;
        mon_bits = '1;
        repeat (mon_dv / 2) @(negedge clk);
        mon_bits[0] = txd;
        for (int k = 1; k < mon_nb; k++) begin
          repeat (mon_dv) @(negedge clk);
          mon_bits[k] = txd;
        end
        if (mon_n < 64) begin
          mon_d[mon_n] = mon_bits[7:1];
          mon_p[mon_n] = mon_bits[8];
          mon_s[mon_n] = (mon_bits[0] == 1'b0) && mon_bits[9] && (mon_nb == 10 || mon_bits[10]);
          mon_t[mon_n] = mon_t0;
        end
        mon_n = mon_n + 1;
      end
    end
  end

  task automatic summary_and_finish();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    tests = tests + 1;
    fails = fails + 1;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    summary_and_finish();
  end

  task automatic check(input string tag, input bit ok, input int got, input int expv);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s got %0h exp %0h", tag, got, expv);
    end
  endtask

  task automatic cfg_write(input logic [4:0] a, input logic [6:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rx_pulse(input logic [6:0] c);
    rx_valid = 1'b1; rx_char = c;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_msg(input int len);
    for (int i = 0; i < len; i++) begin
      msg_valid = 1'b1;
      msg_data  = msg_buf[i];
      msg_last  = (i == len - 1);
      while (msg_ready !== 1'b1) @(negedge clk);
      @(negedge clk);
    end
    msg_valid = 1'b0;
    msg_last  = 1'b0;
  endtask

  task automatic wait_done();
    int k;
    k = 0;
    while (mon_n < exp_n && k < 30000) begin
      @(negedge clk);
      k++;
    end
    repeat (24 * div_of(strap_baud)) @(negedge clk);
  endtask

  task automatic verify(input string tag, input bit chk_sp);
    int dv, nb;
    dv = div_of(strap_baud);
    nb = strap_stop2 ? 11 : 10;
    check({"R12 count (", tag, ")"}, mon_n == exp_n, mon_n, exp_n);
    for (int i = 0; i < exp_n && i < mon_n; i++) begin
      check({tag, " data"}, mon_d[i] == exp_d[i], mon_d[i], exp_d[i]);
      check({"R4 parity (", tag, ")"}, mon_p[i] == exp_par(strap_parity, exp_d[i]),
            mon_p[i], exp_par(strap_parity, exp_d[i]));
      check({"R2/R5 framing (", tag, ")"}, mon_s[i] == 1'b1, mon_s[i], 1);
      if (chk_sp && i > 0)
        check({"R3/R5 spacing (", tag, ")"}, (mon_t[i] - mon_t[i-1]) == nb * dv + 1,
              mon_t[i] - mon_t[i-1], nb * dv + 1);
    end
  endtask

  task automatic run_msg(input int len, input string tag);
    mon_n = 0;
    send_msg(len);
    wait_done();
    verify(tag, 1'b1);
  endtask

  initial begin : main
    rst_n = 1'b0;
    msg_valid = 1'b0; msg_last = 1'b0; msg_data = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    rx_valid = 1'b0; rx_char = '0;
    strap_baud = 2'b11; strap_parity = 2'b11; strap_stop2 = 1'b1; strap_term = 2'b11;
    repeat (5) @(negedge clk);
    check("R1 txd in reset", txd === 1'b1, txd, 1);
    check("R1 msg_ready in reset", msg_ready === 1'b0, msg_ready, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 txd after reset", txd === 1'b1, txd, 1);
    check("R1 msg_ready idle", msg_ready === 1'b0, msg_ready, 0);

    // default straps: 300 baud, space parity, two stops, CR; no header (R8)
    msg_buf[0] = 7'h41;
    exp_n = 2; exp_d[0] = 7'h41; exp_d[1] = 7'h0D;
    run_msg(1, "R6 R8 default");

    // parity x stop sweep at 9600, no terminator
    strap_baud = 2'b00; strap_term = 2'b00;
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 2; s++) begin
        strap_parity = 2'(p); strap_stop2 = 1'(s);
        msg_buf[0] = 7'(7'h35 + p * 4 + s);
        msg_buf[1] = ~msg_buf[0];
        msg_buf[2] = 7'(7'h21 + p * 13 + s * 5);
        exp_n = 3;
        for (int i = 0; i < 3; i++) exp_d[i] = msg_buf[i];
        run_msg(3, "R2 R4 R5 sweep");
      end
    end

    // baud sweep
    strap_parity = 2'b01; strap_stop2 = 1'b0;
    for (int b = 0; b < 4; b++) begin
      strap_baud = 2'(b);
      msg_buf[0] = 7'h2A; msg_buf[1] = 7'h55;
      exp_n = 2; exp_d[0] = 7'h2A; exp_d[1] = 7'h55;
      run_msg(2, "R3 baud sweep");
    end

    // terminator strap sweep
    strap_baud = 2'b00; strap_parity = 2'b00;
    for (int t = 0; t < 4; t++) begin
      strap_term = 2'(t);
      msg_buf[0] = 7'h71;
      exp_d[0] = 7'h71;
      case (t)
        3: begin exp_n = 2; exp_d[1] = 7'h0D; end
        2: begin exp_n = 3; exp_d[1] = 7'h0D; exp_d[2] = 7'h0A; end
        1: begin exp_n = 2; exp_d[1] = 7'h09; end
        default: exp_n = 1;
      endcase
      run_msg(1, "R6 terminator strap");
    end

    // header and user terminator
    strap_term = 2'b11;
    cfg_write(5'd0, 7'h48); cfg_write(5'd1, 7'h44); cfg_write(5'd10, 7'd2);
    cfg_write(5'd16, 7'h58); cfg_write(5'd17, 7'h59); cfg_write(5'd18, 7'h5A);
    cfg_write(5'd26, 7'd3);
    msg_buf[0] = 7'h61; msg_buf[1] = 7'h62;
    exp_n = 7;
    exp_d[0] = 7'h48; exp_d[1] = 7'h44; exp_d[2] = 7'h61; exp_d[3] = 7'h62;
    exp_d[4] = 7'h58; exp_d[5] = 7'h59; exp_d[6] = 7'h5A;
    run_msg(2, "R7 R8 header+user term");
    // header repeats on the next message
    msg_buf[0] = 7'h63;
    exp_n = 6; exp_d[2] = 7'h63; exp_d[3] = 7'h58; exp_d[4] = 7'h59; exp_d[5] = 7'h5A;
    run_msg(1, "R8 header repeat");

    // clearing lengths restores strap terminator, no header
    cfg_write(5'd26, 7'd0); cfg_write(5'd10, 7'd0);
    strap_term = 2'b10;
    msg_buf[0] = 7'h7A;
    exp_n = 3; exp_d[0] = 7'h7A; exp_d[1] = 7'h0D; exp_d[2] = 7'h0A;
    run_msg(1, "R7 strap restored");

    // pacing off: XOFF ignored
    strap_term = 2'b00;
    rx_pulse(7'h13);
    msg_buf[0] = 7'h31; msg_buf[1] = 7'h32;
    exp_n = 2; exp_d[0] = 7'h31; exp_d[1] = 7'h32;
    run_msg(2, "R9 XOFF ignored when off");

    // pacing on: XOFF before message holds, XON releases
    cfg_write(5'd31, 7'd1);
    rx_pulse(7'h13);
    mon_n = 0;
    msg_buf[0] = 7'h41; msg_buf[1] = 7'h42; msg_buf[2] = 7'h43;
    exp_n = 3; exp_d[0] = 7'h41; exp_d[1] = 7'h42; exp_d[2] = 7'h43;
    fork send_msg(3); join_none
    repeat (400) @(negedge clk);
    check("R9 held count", mon_n == 0, mon_n, 0);
    check("R9 held ready", msg_ready === 1'b0, msg_ready, 0);
    rx_pulse(7'h11);
    wait_done();
    verify("R9 XON resume", 1'b1);

    // XOFF in mid-character
    mon_n = 0;
    msg_buf[0] = 7'h4D; msg_buf[1] = 7'h4E; msg_buf[2] = 7'h4F;
    exp_n = 3; exp_d[0] = 7'h4D; exp_d[1] = 7'h4E; exp_d[2] = 7'h4F;
    fork send_msg(3); join_none
    while (txd !== 1'b0) @(negedge clk);
    repeat (10) @(negedge clk);
    rx_pulse(7'h13);
    repeat (400) @(negedge clk);
    check("R10 one char completed", mon_n == 1, mon_n, 1);
    check("R10 char intact", mon_d[0] == 7'h4D && mon_s[0] == 1'b1, mon_d[0], 7'h4D);
    rx_pulse(7'h11);
    wait_done();
    verify("R10 after resume", 1'b0);

    // disabling pacing while held resumes
    rx_pulse(7'h13);
    mon_n = 0;
    msg_buf[0] = 7'h5E; msg_buf[1] = 7'h21;
    exp_n = 2; exp_d[0] = 7'h5E; exp_d[1] = 7'h21;
    fork send_msg(2); join_none
    repeat (300) @(negedge clk);
    check("R11 held before disable", mon_n == 0, mon_n, 0);
    cfg_write(5'd31, 7'd0);
    wait_done();
    verify("R11 resume on disable", 1'b1);

    summary_and_finish();
  end

endmodule